// File: doc/BRIEF.md
# Epoch-Tagged Fetch Control

This block drives the front of an in-order pipeline that always guesses branches as not taken. Once out of reset it issues one instruction-memory request per accepted cycle, each at the previous address plus four. Every request carries a one-bit generation tag, called the epoch. The memory returns that tag, along with the address and the instruction word, on its response. Responses whose tag matches the live epoch go on to decode together with their tag. Stale responses are dropped quietly.

When execute finds a mispredicted branch, it raises a redirect that carries the corrected target and the tag of the branch. If that tag matches the current epoch, the redirect is accepted. The epoch toggles, and in the same cycle the request port switches to the target. Later pipeline stages report their valid bit and their tag. For each stage, the block returns a kill bit that turns a wrong-path instruction into a no-op before it can write a register or touch data memory. No flush signal is broadcast to the earlier stages: the comparison of tags is the only squash mechanism.

Top module: `fetch_epoch_ctrl`

## Requirements
- R1: While `rst_n` is low, `imem_req_valid`, `dec_valid` and `cur_epoch` are 0, and every `stage_kill` bit is 0 when the `stage_valid` bits are 0.
- R2: With no redirect accepted, each accepted request (`imem_req_valid` and `imem_req_ready` both high at a clock edge) is followed by a request at the previous address plus 4. With `imem_req_ready` held high, a new request is accepted on every cycle.
- R3: While `imem_req_ready` is low and no redirect is accepted, `imem_req_valid` stays high and `imem_req_addr` holds its value.
- R4: A redirect is accepted when `redirect_valid` is high and `redirect_tag` equals `cur_epoch`. After that clock edge `cur_epoch` is inverted, and the request following the target is at the target plus 4.
- R5: A redirect whose `redirect_tag` differs from `cur_epoch` is ignored. The epoch, the request address and the request tag are unchanged.
- R6: A response whose `imem_rsp_tag` differs from the live epoch never reaches decode (`dec_valid` stays 0). In the cycle a redirect is accepted, the live epoch is already the inverted value.
- R7: A response whose tag matches the live epoch appears on decode in the same cycle, with `dec_pc` = `imem_rsp_addr`, `dec_inst` = `imem_rsp_data` and `dec_tag` = `imem_rsp_tag`.
- R8: For each stage i, `stage_kill[i]` is high exactly when `stage_valid[i]` is high and `stage_tag[i]` differs from `cur_epoch`.
- R9: A redirect wins over the normal fetch in the same cycle. `imem_req_addr` shows the target and `imem_req_tag` shows the inverted epoch, also when `imem_req_ready` is low. If the request is not accepted, the target is held for the next cycle.
- R10: Consider memory with a fixed two-cycle latency, and a redirect accepted one cycle after its branch was delivered to decode. The decode stream then shows the branch followed directly by the target. The two sequential fetches issued after the branch never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_req_valid | output | 1 | Fetch request present |
| imem_req_ready | input | 1 | Memory accepts the request this cycle |
| imem_req_addr | output | AW | Byte address of the fetch |
| imem_req_tag | output | 1 | Epoch tag of the fetch |
| imem_rsp_valid | input | 1 | Memory response present |
| imem_rsp_addr | input | AW | Address echoed by memory |
| imem_rsp_tag | input | 1 | Epoch tag echoed by memory |
| imem_rsp_data | input | IW | Instruction word |
| redirect_valid | input | 1 | Misprediction reported by execute |
| redirect_tag | input | 1 | Epoch tag of the mispredicted branch |
| redirect_target | input | AW | Corrected fetch address |
| dec_valid | output | 1 | Instruction handed to decode |
| dec_pc | output | AW | Address of that instruction |
| dec_inst | output | IW | Instruction word to decode |
| dec_tag | output | 1 | Epoch tag that travels with the instruction |
| stage_valid | input | NSTAGE | Occupancy of each later stage |
| stage_tag | input | NSTAGE | Epoch tag held by each later stage |
| stage_kill | output | NSTAGE | Turn that stage's instruction into a no-op |
| cur_epoch | output | 1 | Current epoch register |

## Verification
The fetch path is exercised with several input patterns:
- An unbroken sequential run shows whether addresses step by four with no gaps or repeats.
- A stall in the middle of a run shows whether the address is held and whether any instruction is duplicated once fetch resumes.
- An accepted redirect issued while the branch sits in execute shows whether exactly the two in-flight wrong-path fetches are dropped and the target follows the branch.
- A redirect carrying a stale tag shows whether it is ignored.
- A redirect that arrives during a stall shows whether the target is held and whether it wins over the pending sequential address.

Kill outputs are compared for mixed valid and tag patterns under both epoch values.

// File: rtl/fetch_epoch_pkg.sv
`timescale 1ns/1ps
package fetch_epoch_pkg;
  // one-bit generation tag carried by every fetched instruction
  typedef logic epoch_t;
  // byte distance between consecutive instructions
  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/fe_pc_gen.sv
`timescale 1ns/1ps
module fe_pc_gen
  import fetch_epoch_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_ready,
  input  logic          redir_valid,
  input  epoch_t        redir_tag,
  input  logic [AW-1:0] redir_target,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output epoch_t        req_tag,
  output epoch_t        epoch_live,
  output epoch_t        epoch_now
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  logic          running_q, running_d;
  logic [AW-1:0] pc_q, pc_d;
  epoch_t        epoch_q, epoch_d;
  logic          redir_acc, fire, pc_en, epoch_en;

  // next-state logic
  always_comb begin
    redir_acc  = running_q & redir_valid & (redir_tag == epoch_q);
    req_valid  = running_q;
    req_addr   = redir_acc ? redir_target : pc_q;
    req_tag    = redir_acc ? ~epoch_q : epoch_q;
    epoch_live = req_tag;
    epoch_now  = epoch_q;
    fire       = running_q & req_ready;
    running_d  = 1'b1;
    epoch_d    = ~epoch_q;
    epoch_en   = redir_acc;
    pc_en      = fire | redir_acc;
    if (fire) begin
      pc_d = req_addr + STEP;
    end else begin
      pc_d = redir_target;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      pc_q      <= RESET_PC;
      epoch_q   <= 1'b0;
    end else begin
      running_q <= running_d;
      if (pc_en)    pc_q    <= pc_d;
      if (epoch_en) epoch_q <= epoch_d;
    end
  end
endmodule

// File: rtl/fe_rsp_filter.sv
`timescale 1ns/1ps
module fe_rsp_filter
  import fetch_epoch_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 32
) (
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_addr,
  input  epoch_t        rsp_tag,
  input  logic [IW-1:0] rsp_data,
  input  epoch_t        epoch_live,
  output logic          out_valid,
  output logic [AW-1:0] out_pc,
  output logic [IW-1:0] out_inst,
  output epoch_t        out_tag
);
  // responses from an older generation are dropped here
  always_comb begin
    out_valid = rsp_valid & (rsp_tag == epoch_live);
    out_pc    = rsp_addr;
    out_inst  = rsp_data;
    out_tag   = rsp_tag;
  end
endmodule

// File: rtl/fe_kill_cmp.sv
`timescale 1ns/1ps
module fe_kill_cmp
  import fetch_epoch_pkg::*;
#(
  parameter int unsigned NSTAGE = 4
) (
  input  logic [NSTAGE-1:0] stage_valid,
  input  logic [NSTAGE-1:0] stage_tag,
  input  epoch_t            epoch_now,
  output logic [NSTAGE-1:0] stage_kill
);
  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    assign stage_kill[g] = stage_valid[g] & (stage_tag[g] != epoch_now);
  end
endmodule

// File: rtl/fetch_epoch_ctrl.sv
`timescale 1ns/1ps
module fetch_epoch_ctrl
  import fetch_epoch_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   IW       = 32,
  parameter int unsigned   NSTAGE   = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              imem_req_valid,
  input  logic              imem_req_ready,
  output logic [AW-1:0]     imem_req_addr,
  output logic              imem_req_tag,
  input  logic              imem_rsp_valid,
  input  logic [AW-1:0]     imem_rsp_addr,
  input  logic              imem_rsp_tag,
  input  logic [IW-1:0]     imem_rsp_data,
  input  logic              redirect_valid,
  input  logic              redirect_tag,
  input  logic [AW-1:0]     redirect_target,
  output logic              dec_valid,
  output logic [AW-1:0]     dec_pc,
  output logic [IW-1:0]     dec_inst,
  output logic              dec_tag,
  input  logic [NSTAGE-1:0] stage_valid,
  input  logic [NSTAGE-1:0] stage_tag,
  output logic [NSTAGE-1:0] stage_kill,
  output logic              cur_epoch
);
  epoch_t epoch_live;
  epoch_t epoch_now;

  fe_pc_gen #(.AW(AW), .RESET_PC(RESET_PC)) u_pc_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (imem_req_ready),
    .redir_valid  (redirect_valid),
    .redir_tag    (redirect_tag),
    .redir_target (redirect_target),
    .req_valid    (imem_req_valid),
    .req_addr     (imem_req_addr),
    .req_tag      (imem_req_tag),
    .epoch_live   (epoch_live),
    .epoch_now    (epoch_now)
  );

  fe_rsp_filter #(.AW(AW), .IW(IW)) u_rsp_filter (
    .rsp_valid  (imem_rsp_valid),
    .rsp_addr   (imem_rsp_addr),
    .rsp_tag    (imem_rsp_tag),
    .rsp_data   (imem_rsp_data),
    .epoch_live (epoch_live),
    .out_valid  (dec_valid),
    .out_pc     (dec_pc),
    .out_inst   (dec_inst),
    .out_tag    (dec_tag)
  );

  fe_kill_cmp #(.NSTAGE(NSTAGE)) u_kill_cmp (
    .stage_valid (stage_valid),
    .stage_tag   (stage_tag),
    .epoch_now   (epoch_now),
    .stage_kill  (stage_kill)
  );

  assign cur_epoch = epoch_now;
endmodule

// File: rtl/fetch_epoch_ctrl_chk.sv
`timescale 1ns/1ps
module fetch_epoch_ctrl_chk #(
  parameter int unsigned AW     = 32,
  parameter int unsigned NSTAGE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              imem_req_valid,
  input logic              imem_req_ready,
  input logic [AW-1:0]     imem_req_addr,
  input logic              imem_req_tag,
  input logic              imem_rsp_valid,
  input logic              imem_rsp_tag,
  input logic              redirect_valid,
  input logic              redirect_tag,
  input logic [AW-1:0]     redirect_target,
  input logic              dec_valid,
  input logic [NSTAGE-1:0] stage_valid,
  input logic [NSTAGE-1:0] stage_tag,
  input logic [NSTAGE-1:0] stage_kill,
  input logic              cur_epoch
);
  logic take;
  assign take = imem_req_valid & redirect_valid & (redirect_tag == cur_epoch);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req_valid && imem_req_ready && !take) |=>
      (take || imem_req_addr == $past(imem_req_addr) + AW'(4)));

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req_valid && !imem_req_ready && !take) |=>
      (take || ($stable(imem_req_addr) && imem_req_valid)));

  assert_epoch_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cur_epoch != $past(cur_epoch)));

  assert_stale_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && redirect_tag != cur_epoch) |=> $stable(cur_epoch));

  assert_drop_stale_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rsp_valid && !redirect_valid && imem_rsp_tag != cur_epoch) |-> !dec_valid);

  assert_redirect_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (imem_req_addr == redirect_target && imem_req_tag != cur_epoch));

  for (genvar g = 0; g < NSTAGE; g++) begin : g_kill
    assert_kill_stale_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_valid[g] && stage_tag[g] != cur_epoch) |-> stage_kill[g]);
    assert_keep_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!stage_valid[g] || stage_tag[g] == cur_epoch) |-> !stage_kill[g]);
  end
endmodule

bind fetch_epoch_ctrl fetch_epoch_ctrl_chk #(.AW(AW), .NSTAGE(NSTAGE)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .imem_req_valid  (imem_req_valid),
  .imem_req_ready  (imem_req_ready),
  .imem_req_addr   (imem_req_addr),
  .imem_req_tag    (imem_req_tag),
  .imem_rsp_valid  (imem_rsp_valid),
  .imem_rsp_tag    (imem_rsp_tag),
  .redirect_valid  (redirect_valid),
  .redirect_tag    (redirect_tag),
  .redirect_target (redirect_target),
  .dec_valid       (dec_valid),
  .stage_valid     (stage_valid),
  .stage_tag       (stage_tag),
  .stage_kill      (stage_kill),
  .cur_epoch       (cur_epoch)
);

// File: tb/fetch_epoch_ctrl_test.sv
`timescale 1ns/1ps
module fetch_epoch_ctrl_test;
  localparam int AW = 32;
  localparam int IW = 32;
  localparam int NS = 4;

  logic          clk, rst_n;
  logic          imem_req_valid, imem_req_ready, imem_req_tag;
  logic [AW-1:0] imem_req_addr;
  logic          imem_rsp_valid, imem_rsp_tag;
  logic [AW-1:0] imem_rsp_addr;
  logic [IW-1:0] imem_rsp_data;
  logic          redirect_valid, redirect_tag;
  logic [AW-1:0] redirect_target;
  logic          dec_valid, dec_tag;
  logic [AW-1:0] dec_pc;
  logic [IW-1:0] dec_inst;
  logic [NS-1:0] stage_valid, stage_tag, stage_kill;
  logic          cur_epoch;

  fetch_epoch_ctrl #(.AW(AW), .IW(IW), .NSTAGE(NS)) uut (
    .clk(clk), .rst_n(rst_n),
    .imem_req_valid(imem_req_valid), .imem_req_ready(imem_req_ready),
    .imem_req_addr(imem_req_addr), .imem_req_tag(imem_req_tag),
    .imem_rsp_valid(imem_rsp_valid), .imem_rsp_addr(imem_rsp_addr),
    .imem_rsp_tag(imem_rsp_tag), .imem_rsp_data(imem_rsp_data),
    .redirect_valid(redirect_valid), .redirect_tag(redirect_tag),
    .redirect_target(redirect_target),
    .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_inst(dec_inst), .dec_tag(dec_tag),
    .stage_valid(stage_valid), .stage_tag(stage_tag), .stage_kill(stage_kill),
    .cur_epoch(cur_epoch)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model: fixed two-cycle latency, echoes address and tag, data = ~address
  logic          m1_v, m2_v, m1_t, m2_t;
  logic [AW-1:0] m1_a, m2_a;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_v <= 1'b0; m2_v <= 1'b0;
      m1_t <= 1'b0; m2_t <= 1'b0;
      m1_a <= '0;   m2_a <= '0;
    end else begin
      m1_v <= imem_req_valid & imem_req_ready;
      m1_a <= imem_req_addr;
      m1_t <= imem_req_tag;
      m2_v <= m1_v; m2_a <= m1_a; m2_t <= m1_t;
    end
  end
  assign imem_rsp_valid = m2_v;
  assign imem_rsp_addr  = m2_a;
  assign imem_rsp_tag   = m2_t;
  assign imem_rsp_data  = ~m2_a;

  logic [AW-1:0] exp_q[$];
  bit            sb_open;
  logic          exp_epoch;
  int            n_chk, n_fail;
  logic [AW-1:0] held;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_run(input logic [AW-1:0] start, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(start + AW'(4 * i));
  endtask

  task automatic wait_size(input int n);
    do begin
      @(negedge clk); #3;
    end while (exp_q.size() > n);
  endtask

  task automatic kill_check(input logic [NS-1:0] v, input logic [NS-1:0] t);
    logic [NS-1:0] e;
    stage_valid = v; stage_tag = t;
    #1;
    e = v & (t ^ {NS{exp_epoch}});
    chk(stage_kill == e, "R8", "stage kill", 32'(stage_kill), 32'(e));
  endtask

  // monitor: pops the expected stream as decode deliveries appear
  initial begin
    logic [AW-1:0] e;
    forever begin
      @(negedge clk); #2;
      if (rst_n && sb_open && dec_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "wrong-path instruction delivered", dec_pc, '0);
        end else begin
          e = exp_q.pop_front();
          chk(dec_pc == e, "R2/R10", "decode pc order", dec_pc, e);
          chk(dec_inst == ~e, "R7", "decode instruction word", dec_inst, ~e);
          chk(dec_tag == exp_epoch, "R7", "decode tag", 32'(dec_tag), 32'(exp_epoch));
        end
      end
    end
  end

  // watchdog
  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; sb_open = 0; exp_epoch = 1'b0;
    rst_n = 1'b0; imem_req_ready = 1'b1;
    redirect_valid = 1'b0; redirect_tag = 1'b0; redirect_target = '0;
    stage_valid = '0; stage_tag = '0;
    #23;
    // R1: reset state
    chk(imem_req_valid == 1'b0, "R1", "request during reset", 32'(imem_req_valid), 0);
    chk(dec_valid == 1'b0, "R1", "decode during reset", 32'(dec_valid), 0);
    chk(cur_epoch == 1'b0, "R1", "epoch during reset", 32'(cur_epoch), 0);
    chk(stage_kill == '0, "R1", "kill during reset", 32'(stage_kill), 0);
    push_run(32'h0, 17);          // 0x00 .. 0x40, 0x40 is the branch
    sb_open = 1;
    #8 rst_n = 1'b1;              // released at t=31, after a falling edge

    // R3: stall in the middle of the sequential run
    wait_size(10);
    imem_req_ready = 1'b0;
    held = imem_req_addr;
    repeat (3) begin
      @(negedge clk); #3;
      chk(imem_req_addr == held, "R3", "address held in stall", imem_req_addr, held);
      chk(imem_req_valid == 1'b1, "R3", "request kept valid", 32'(imem_req_valid), 1);
    end
    imem_req_ready = 1'b1;

    // R10 R4 R9: branch at 0x40 reaches decode; redirect one cycle later
    wait_size(0);
    @(negedge clk); #1;
    redirect_valid = 1'b1; redirect_tag = exp_epoch; redirect_target = 32'h200;
    push_run(32'h200, 25);        // 0x200 .. 0x260
    #2;
    chk(imem_req_addr == 32'h200, "R9", "redirect wins address", imem_req_addr, 32'h200);
    chk(imem_req_tag == ~exp_epoch, "R9", "redirect request tag", 32'(imem_req_tag), 32'(~exp_epoch));
    @(negedge clk); #1;
    redirect_valid = 1'b0;
    exp_epoch = ~exp_epoch;
    #2;
    chk(cur_epoch == exp_epoch, "R4", "epoch toggled", 32'(cur_epoch), 32'(exp_epoch));
    chk(imem_req_addr == 32'h204, "R4", "address after target", imem_req_addr, 32'h204);

    // R5: redirect carrying a stale tag is ignored
    wait_size(16);
    @(negedge clk); #1;
    redirect_valid = 1'b1; redirect_tag = ~exp_epoch; redirect_target = 32'h800;
    #2;
    chk(imem_req_addr != 32'h800, "R5", "stale redirect address", imem_req_addr, 32'h800);
    chk(imem_req_tag == exp_epoch, "R5", "stale redirect tag", 32'(imem_req_tag), 32'(exp_epoch));
    @(negedge clk); #1;
    redirect_valid = 1'b0;
    #2;
    chk(cur_epoch == exp_epoch, "R5", "epoch unchanged", 32'(cur_epoch), 32'(exp_epoch));

    // R9 R3: accepted redirect while memory stalls
    wait_size(0);
    @(negedge clk); #1;
    imem_req_ready = 1'b0;
    redirect_valid = 1'b1; redirect_tag = exp_epoch; redirect_target = 32'h100;
    push_run(32'h100, 5);
    #2;
    chk(imem_req_addr == 32'h100, "R9", "target shown while stalled", imem_req_addr, 32'h100);
    @(negedge clk); #1;
    redirect_valid = 1'b0; imem_req_ready = 1'b1;
    exp_epoch = ~exp_epoch;
    #2;
    chk(imem_req_addr == 32'h100, "R9", "target held after stall", imem_req_addr, 32'h100);
    chk(cur_epoch == exp_epoch, "R4", "epoch toggled again", 32'(cur_epoch), 32'(exp_epoch));
    wait_size(0);
    sb_open = 0;

    // R8: kill outputs under both epochs
    @(negedge clk); #1;
    kill_check(4'b1011, 4'b0110);
    kill_check(4'b1111, 4'b0000);
    kill_check(4'b0000, 4'b1111);
    @(negedge clk); #1;
    redirect_valid = 1'b1; redirect_tag = exp_epoch; redirect_target = 32'h0;
    @(negedge clk); #1;
    redirect_valid = 1'b0;
    exp_epoch = ~exp_epoch;
    chk(cur_epoch == exp_epoch, "R4", "epoch before kill test", 32'(cur_epoch), 32'(exp_epoch));
    kill_check(4'b1011, 4'b0110);
    kill_check(4'b1111, 4'b1010);

    chk(exp_q.size() == 0, "R10", "expected stream drained", 32'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule